// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block prioritises interrupt requests for a single CPU. Each of `N_SRC` request lines is given one of three service levels (low, medium, high) through a two-bit code, and each level can be switched on or off as a whole. A non-maskable input outranks every level. The controller presents one vector number together with a valid flag. When the CPU acknowledges, the controller records the level it has entered.

A four-bit in-service register tracks the nesting. A request can only interrupt a running handler when its level is strictly above every level already in service. A return strobe retires the innermost level. Among requests at the same level the lowest source index wins. For the low level only, an optional rotating search begins just past the last low source that was acknowledged, so every low source is reached within a bounded number of services.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Source i has level code `lvl_i[2i+1:2i]`: 0 = none, 1 = low, 2 = medium, 3 = high. A source with code 0, or whose level has a clear bit in `lvl_en_i` (bit 0 low, bit 1 medium, bit 2 high), is never presented.
- R2: With `gie_i` low, no source request is presented; only the non-maskable input can be.
- R3: `nmi_i` outranks every level and is presented as vector `N_SRC` whenever the non-maskable level (bit 3 of `active_o`) is not in service.
- R4: A higher-level request wins over a lower-level one. Within a level with static order, the lowest source index wins. Source i is presented as vector i.
- R5: A source is eligible only when its level is strictly above the highest level in service. Bits 0, 1, 2 and 3 of `active_o` stand for low, medium, high and non-maskable.
- R6: `ack_i` while `irq_valid_o` is high sets the `active_o` bit of the presented level from the next cycle.
- R7: `reti_i` clears only the highest set bit of `active_o` in the next cycle.
- R8: With `rr_en_i` high, the low-level search starts at the source just after the last low source acknowledged in that mode and wraps around. After reset it starts at source 0. Medium and high levels always use static order.
- R9: `irq_valid_o` and `irq_vec_o` follow the inputs combinationally, so the valid flag falls in the same cycle the winning request drops.
- R10: After reset `active_o` is 0 and, with no request, `irq_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Request lines |
| lvl_i | input | 2*N_SRC | Two-bit level code per source |
| lvl_en_i | input | 3 | Per-level enable |
| gie_i | input | 1 | Global enable for maskable sources |
| rr_en_i | input | 1 | Low-level rotation enable |
| nmi_i | input | 1 | Non-maskable request |
| ack_i | input | 1 | CPU acknowledge of presented vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_valid_o | output | 1 | A vector is presented |
| irq_vec_o | output | $clog2(N_SRC+1) | Presented vector |
| active_o | output | 4 | In-service levels |

## Verification
The assertions assume that `ack_i` is raised only while a vector is presented, and that `ack_i` and `reti_i` are never high in the same cycle. The stimulus never combines the two strobes and acknowledges only after it has checked that the output is valid. The assertions also assume that `reti_i` comes only when some level is in service. The bench issues each return to match a handler it has already entered.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NUM_LVL = 3;
  localparam int ACT_W   = NUM_LVL + 1;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MED  = 2'd2,
    LVL_HIGH = 2'd3
  } lvl_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] start_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // first set bit at or after start_i, wrapping
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(start_i) + k;
      if (j >= N) j = j - N;
      if (!hit_o && mask_i[j]) begin
        hit_o = 1'b1;
        idx_o = IW'(j);
      end
    end
  end
endmodule

// File: rtl/irq_nest_state.sv
module irq_nest_state #(
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] set_i,
  input  logic          reti_i,
  output logic [LW-1:0] active_o
);
  logic [LW-1:0] clr;

  always_comb begin
    clr = '0;
    for (int k = 0; k < LW; k++)
      if (active_o[k]) clr = LW'(1) << k;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_o <= '0;
    else         active_o <= (active_o & ~(reti_i ? clr : '0)) | set_i;
  end

  // R6
  ack_sets_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((active_o & $past(set_i)) == $past(set_i)));

  // R7
  reti_clears_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && set_i == '0 && active_o != '0) |=>
      ($countones(active_o) == $countones($past(active_o)) - 1));

  // R7
  reti_keeps_lower_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && set_i == '0) |=> ((active_o & ~$past(active_o)) == '0));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int VW   = $clog2(N_SRC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   req_i,
  input  logic [2*N_SRC-1:0] lvl_i,
  input  logic [NUM_LVL-1:0] lvl_en_i,
  input  logic               gie_i,
  input  logic               rr_en_i,
  input  logic               nmi_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_valid_o,
  output logic [VW-1:0]      irq_vec_o,
  output logic [ACT_W-1:0]   active_o
);
  localparam logic [VW-1:0] NMI_VEC = VW'(N_SRC);
  localparam logic [IW-1:0] LAST_IX = IW'(N_SRC - 1);

  logic [2:0]         top_lvl;
  logic [N_SRC-1:0]   lvl_mask [NUM_LVL];
  logic [IW-1:0]      lvl_start[NUM_LVL];
  logic [NUM_LVL-1:0] lvl_hit;
  logic [IW-1:0]      lvl_idx  [NUM_LVL];
  logic [IW-1:0]      last_low;
  logic [IW-1:0]      rr_start;
  logic               nmi_ok;
  logic [ACT_W-1:0]   win_set;
  logic [ACT_W-1:0]   take_set;

  always_comb begin
    top_lvl = 3'd0;
    for (int k = 0; k < ACT_W; k++)
      if (active_o[k]) top_lvl = 3'(k + 1);
  end

  assign rr_start = (last_low == LAST_IX) ? '0 : last_low + IW'(1);

  for (genvar gl = 0; gl < NUM_LVL; gl++) begin : g_lvl
    for (genvar gs = 0; gs < N_SRC; gs++) begin : g_src
      assign lvl_mask[gl][gs] = req_i[gs] && gie_i && lvl_en_i[gl]
                             && (lvl_i[2*gs +: 2] == 2'(gl + 1))
                             && (top_lvl < 3'(gl + 1));
    end
    if (gl == 0) begin : g_rr
      assign lvl_start[gl] = rr_en_i ? rr_start : '0;
    end else begin : g_fix
      assign lvl_start[gl] = '0;
    end
    irq_pick #(.N(N_SRC), .IW(IW)) u_pick (
      .mask_i (lvl_mask[gl]),
      .start_i(lvl_start[gl]),
      .hit_o  (lvl_hit[gl]),
      .idx_o  (lvl_idx[gl])
    );
  end

  assign nmi_ok = nmi_i && !active_o[ACT_W-1];

  always_comb begin
    win_set   = '0;
    irq_vec_o = '0;
    if (nmi_ok) begin
      win_set   = ACT_W'(1) << (ACT_W - 1);
      irq_vec_o = NMI_VEC;
    end else begin
      for (int k = 0; k < NUM_LVL; k++)
        if (lvl_hit[k]) begin
          win_set   = ACT_W'(1) << k;
          irq_vec_o = VW'(lvl_idx[k]);
        end
    end
  end

  assign irq_valid_o = win_set != '0;
  assign take_set    = (ack_i && irq_valid_o) ? win_set : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          last_low <= LAST_IX;
    else if (rr_en_i && take_set[0])      last_low <= lvl_idx[0];
  end

  irq_nest_state #(.LW(ACT_W)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (take_set),
    .reti_i  (reti_i),
    .active_o(active_o)
  );

  // R2
  gie_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gie_i && !nmi_i) |-> !irq_valid_o);

  // R3
  nmi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !active_o[ACT_W-1]) |-> (irq_valid_o && irq_vec_o == NMI_VEC));

  // R5
  preempt_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (win_set > active_o));

  // R8
  rr_record_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_en_i && take_set[0]) |=> (last_low == $past(irq_vec_o[IW-1:0])));
endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic [7:0] lvl_i = '0;
  logic [2:0] lvl_en_i = '0;
  logic       gie_i = 1'b0, rr_en_i = 1'b0, nmi_i = 1'b0, ack_i = 1'b0, reti_i = 1'b0;
  logic       irq_valid_o;
  logic [2:0] irq_vec_o;
  logic [3:0] active_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] m_act = '0;
  int m_last = N - 1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_nest_ctrl #(.N_SRC(N)) dut (.*);

  // reference: returns level (0 none, 1..3, 4 nmi) and vector
  function automatic void model(output int lv, output int vec);
    int top, s, j;
    top = 0;
    for (int k = 0; k < 4; k++) if (m_act[k]) top = k + 1;
    lv = 0; vec = 0;
    if (nmi_i && !m_act[3]) begin lv = 4; vec = N; return; end
    for (int l = 3; l >= 1; l--) begin
      if (l <= top || !gie_i || !lvl_en_i[l-1]) continue;
      s = (l == 1 && rr_en_i) ? (m_last + 1) % N : 0;
      for (int k = 0; k < N; k++) begin
        j = (s + k) % N;
        if (req_i[j] && int'(lvl_i[2*j +: 2]) == l) begin lv = l; vec = j; return; end
      end
    end
  endfunction

  task automatic check(string tag);
    int lv, vec;
    model(lv, vec);
    checks++;
    if (irq_valid_o !== (lv != 0) || (lv != 0 && int'(irq_vec_o) != vec) || active_o !== m_act) begin
      errors++;
      $display("FAIL %s: valid=%0b vec=%0d act=%b expected valid=%0b vec=%0d act=%b",
               tag, irq_valid_o, irq_vec_o, active_o, lv != 0, vec, m_act);
    end
  endtask

  task automatic expect_vec(string tag, int v);
    checks++;
    if (!irq_valid_o || int'(irq_vec_o) != v) begin
      errors++;
      $display("FAIL %s: valid=%0b vec=%0d expected valid=1 vec=%0d", tag, irq_valid_o, irq_vec_o, v);
    end
  endtask

  task automatic do_ack(string tag);
    int lv, vec;
    @(negedge clk_i);
    model(lv, vec);
    if (lv != 0) begin
      m_act[lv-1] = 1'b1;
      if (lv == 1 && rr_en_i) m_last = vec;
    end
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    #1 check(tag);
  endtask

  task automatic do_reti(string tag);
    @(negedge clk_i);
    for (int k = 3; k >= 0; k--) if (m_act[k]) begin m_act[k] = 1'b0; break; end
    reti_i = 1'b1;
    @(negedge clk_i);
    reti_i = 1'b0;
    #1 check(tag);
  endtask

  task automatic set_in(logic [3:0] r, string tag);
    @(negedge clk_i);
    req_i = r;
    #1 check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: expired expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1 check("R10 reset");

    // R1 R2 R4 sweep over level maps and requests, idle state
    for (int a = 0; a < 256; a++) begin
      for (int r = 0; r < 16; r++) begin
        @(negedge clk_i);
        lvl_i = 8'(a);
        req_i = 4'(r);
        lvl_en_i = ((a + r) % 5 == 0) ? 3'(a % 8) : 3'b111;
        gie_i = (a % 7 != 0);
        #1 check("R1_R2_R4 sweep");
      end
    end

    // nesting: src0 low, src1 med, src2 high, src3 low
    @(negedge clk_i);
    lvl_i = 8'b01_11_10_01; lvl_en_i = 3'b111; gie_i = 1'b1; req_i = '0;
    set_in(4'b0001, "R4 low alone");
    expect_vec("R4 low vec0", 0);
    do_ack("R6 low ack");
    set_in(4'b0001, "R5 same level blocked");
    set_in(4'b0011, "R5 medium preempts");
    expect_vec("R5 medium vec1", 1);
    do_ack("R6 medium ack");
    set_in(4'b0111, "R5 high preempts");
    do_ack("R6 high ack");
    set_in(4'b0111, "R5 all blocked at high");
    do_reti("R7 retire high");
    do_reti("R7 retire medium");
    do_reti("R7 retire low");
    set_in(4'b0100, "R9 high present");
    set_in(4'b0000, "R9 drop same cycle");

    // NMI
    @(negedge clk_i);
    gie_i = 1'b0; nmi_i = 1'b1; req_i = 4'b0100;
    #1 check("R3 nmi with gie low");
    expect_vec("R3 nmi vector", N);
    do_ack("R3 nmi ack");
    @(negedge clk_i); gie_i = 1'b1;
    #1 check("R5 nothing above nmi");
    @(negedge clk_i); nmi_i = 1'b0;
    do_reti("R7 retire nmi");

    // round robin among four low sources: expect 0,1,2,3,0,1
    @(negedge clk_i);
    lvl_i = 8'b01_01_01_01; rr_en_i = 1'b1; req_i = 4'b1111;
    for (int n = 0; n < 6; n++) begin
      #1 expect_vec("R8 rotation", n % N);
      do_ack("R8 rr ack");
      do_reti("R8 rr reti");
    end
    @(negedge clk_i); rr_en_i = 1'b0;
    for (int n = 0; n < 2; n++) begin
      #1 expect_vec("R4 static after rr", 0);
      do_ack("R4 static ack");
      do_reti("R4 static reti");
    end
    // rotation does not touch medium level
    @(negedge clk_i);
    lvl_i = 8'b10_10_01_01; rr_en_i = 1'b1;
    #1 expect_vec("R8 medium static", 2);
    lvl_en_i = 3'b001;
    #1 check("R1 medium disabled");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule